// File: doc/BRIEF.md
# Sticky Translation Fault Status Register

This block holds the 64-bit status word that describes the most recent address translation fault. When the translation logic reports a fault with a one-cycle strobe, the register is rebuilt from the fault attributes: the access direction, the context class in use, whether the page had side effects, a fault-type code and the 8-bit address space identifier. Bits from the earlier value are not kept, with one exception. If the earlier fault had not yet been cleared by software, the new word flags that an older fault was overwritten.

Software can replace the whole status word through a write port and can read it through a read port. A build-time parameter adds a companion register for the data side. This register captures the faulting virtual address on the same strobe, and software can also write and read it. When the parameter is off, the address register reads as zero. Trap delivery is outside this block.

Top module: `fault_status_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, both the status register and the address register become zero.
- R2: On a clock edge with `flt_stb` high, status bit 0 (valid) becomes 1.
- R3: On a fault, status bit 1 (overwrite) takes the value that status bit 0 had just before that edge. A second fault with no clear in between sets it. A fault that follows a software write of bit 0 = 0 leaves it at 0.
- R4: On a fault, status bit 2 equals `flt_write` (1 = store, 0 = load).
- R5: On a fault, status bits 5:4 hold `flt_ctx`, encoded as 0 = primary, 1 = secondary, 2 = nucleus.
- R6: On a fault, status bit 6 equals `flt_side`.
- R7: On a fault, status bits 7 and up hold `flt_type` (bits 12:7 at the default width of 6), and bits 23:16 hold `flt_space`.
- R8: On a fault, every status bit not named in R2 to R7 becomes 0, whatever its earlier value was. At default widths these are bit 3, bits 15:13 and bits 63:24.
- R9: On an edge with `sw_we` high, `sw_sel` = 0 and no fault, the status register takes `sw_wdata`. With `sw_sel` = 1, the address register takes it.
- R10: When a fault and a software write to either register occur on the same edge, the fault result is stored and the software data is dropped.
- R11: With `HAS_ADDR` = 1, the address register takes `flt_addr` on every fault edge.
- R12: On an edge with neither a fault nor a software write, both registers keep their values. Changes on the fault attribute inputs have no effect.
- R13: `rd_data` shows the status register when `rd_sel` = 0 and the address register when `rd_sel` = 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flt_stb | input | 1 | Fault report strobe, one cycle per fault |
| flt_write | input | 1 | Faulting access was a store |
| flt_ctx | input | 2 | Context class: 0 primary, 1 secondary, 2 nucleus |
| flt_side | input | 1 | Faulting page had side effects |
| flt_type | input | FT_W (6) | Fault-type code |
| flt_space | input | 8 | Address space identifier |
| flt_addr | input | DW (64) | Faulting virtual address |
| sw_we | input | 1 | Software write enable |
| sw_sel | input | 1 | Software write target: 0 status, 1 address |
| sw_wdata | input | DW (64) | Software write data |
| rd_sel | input | 1 | Read select: 0 status, 1 address |
| rd_data | output | DW (64) | Read data |

## Verification
A fault strobe and a software write can land on the same clock edge, and the fault must take precedence. The bench provokes this by raising `flt_stb` together with `sw_we` in one cycle. It does this once with `sw_sel` = 0 and all-ones data, and once with `sw_sel` = 1. Each result is judged by reading both registers back. The status word must equal the packed fault fields, with the overwrite bit taken from the previous valid bit. The address register must hold `flt_addr`, with no trace of the software data in either register.

// File: rtl/fsr_pkg.sv
// Package: shared field positions and context encoding for the fault
// status register. Assumes a status word of at least 24 bits.
package fsr_pkg;

    // Context class carried in the status word.
    typedef enum logic [1:0] {
        CTX_PRIMARY   = 2'd0,
        CTX_SECONDARY = 2'd1,
        CTX_NUCLEUS   = 2'd2
    } fsr_ctx_e;

    // Bit positions inside the status word.
    localparam int unsigned POS_VALID = 0;
    localparam int unsigned POS_OVWR  = 1;
    localparam int unsigned POS_WRITE = 2;
    localparam int unsigned POS_CTX   = 4;
    localparam int unsigned CTX_W     = 2;
    localparam int unsigned POS_SIDE  = 6;
    localparam int unsigned POS_TYPE  = 7;
    localparam int unsigned POS_SPACE = 16;
    localparam int unsigned SPACE_W   = 8;
    localparam int unsigned TYPE_MAX  = POS_SPACE - POS_TYPE;

endpackage

// File: rtl/fsr_field_pack.sv
// Module: fsr_field_pack
// Builds the status word for a new fault from the fault attributes and the
// valid bit of the current word. Purely combinational. Assumes
// FT_W <= TYPE_MAX so that the type field stays below the space field.
module fsr_field_pack
    import fsr_pkg::*;
#(
    parameter int unsigned DW   = 64,
    parameter int unsigned FT_W = 6
) (
    input  logic               prev_valid,
    input  logic               f_write,
    input  logic [CTX_W-1:0]   f_ctx,
    input  logic               f_side,
    input  logic [FT_W-1:0]    f_type,
    input  logic [SPACE_W-1:0] f_space,
    output logic [DW-1:0]      word
);

    localparam int unsigned TYPE_TOP  = POS_TYPE + FT_W - 1;
    localparam int unsigned SPACE_TOP = POS_SPACE + SPACE_W - 1;

    // Place each attribute at its position and leave every other bit clear.
    always_comb begin
        word                         = '0;
        word[POS_VALID]              = 1'b1;
        word[POS_OVWR]               = prev_valid;
        word[POS_WRITE]              = f_write;
        word[POS_CTX +: CTX_W]       = f_ctx;
        word[POS_SIDE]               = f_side;
        word[TYPE_TOP:POS_TYPE]      = f_type;
        word[SPACE_TOP:POS_SPACE]    = f_space;
    end

endmodule

// File: rtl/fsr_status_reg.sv
// Module: fsr_status_reg
// Holds the status word. A fault load takes priority over a software write.
// Assumes a synchronous active-low reset.
module fsr_status_reg #(
    parameter int unsigned DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fault_ld,
    input  logic [DW-1:0] fault_word,
    input  logic          sw_ld,
    input  logic [DW-1:0] sw_word,
    output logic [DW-1:0] q
);

    // Register update: reset, then fault, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (fault_ld) q <= fault_word;
        else if (sw_ld)    q <= sw_word;
    end

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_ld && !sw_ld) |=> $stable(q)); // R12

    AST_STAT_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ld && !fault_ld) |=> (q == $past(sw_word))); // R9

endmodule

// File: rtl/fsr_addr_reg.sv
// Module: fsr_addr_reg
// Companion register holding the faulting virtual address on the data side.
// A fault capture takes priority over a software write. Synchronous
// active-low reset.
module fsr_addr_reg #(
    parameter int unsigned DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] cap_addr,
    input  logic          sw_ld,
    input  logic [DW-1:0] sw_word,
    output logic [DW-1:0] q
);

    // Register update: reset, then fault capture, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (cap)   q <= cap_addr;
        else if (sw_ld) q <= sw_word;
    end

    AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (q == $past(cap_addr))); // R11

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !sw_ld) |=> $stable(q)); // R12

endmodule

// File: rtl/fault_status_unit.sv
// Module: fault_status_unit
// Top level of the sticky fault status register. It packs the fault
// attributes, loads the status word, optionally captures the fault address
// (HAS_ADDR) and offers a software write port and a read port.
// Assumes flt_stb is a single-cycle strobe per fault and a synchronous
// active-low reset.
module fault_status_unit
    import fsr_pkg::*;
#(
    parameter int unsigned DW       = 64,
    parameter int unsigned FT_W     = 6,
    parameter bit          HAS_ADDR = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flt_stb,
    input  logic               flt_write,
    input  logic [1:0]         flt_ctx,
    input  logic               flt_side,
    input  logic [FT_W-1:0]    flt_type,
    input  logic [7:0]         flt_space,
    input  logic [DW-1:0]      flt_addr,
    input  logic               sw_we,
    input  logic               sw_sel,
    input  logic [DW-1:0]      sw_wdata,
    input  logic               rd_sel,
    output logic [DW-1:0]      rd_data
);

    localparam int unsigned TYPE_TOP  = POS_TYPE + FT_W - 1;
    localparam int unsigned SPACE_TOP = POS_SPACE + SPACE_W - 1;

    logic [DW-1:0] stat_q;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] new_word;
    logic          sw_stat_ld;
    logic          sw_addr_ld;

    // Decode the software write target.
    always_comb begin
        sw_stat_ld = sw_we && !sw_sel;
        sw_addr_ld = sw_we &&  sw_sel;
    end

    fsr_field_pack #(.DW(DW), .FT_W(FT_W)) u_pack (
        .prev_valid (stat_q[POS_VALID]),
        .f_write    (flt_write),
        .f_ctx      (flt_ctx),
        .f_side     (flt_side),
        .f_type     (flt_type),
        .f_space    (flt_space),
        .word       (new_word)
    );

    fsr_status_reg #(.DW(DW)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_ld   (flt_stb),
        .fault_word (new_word),
        .sw_ld      (sw_stat_ld),
        .sw_word    (sw_wdata),
        .q          (stat_q)
    );

    generate
        if (HAS_ADDR) begin : g_addr
            fsr_addr_reg #(.DW(DW)) u_addr (
                .clk      (clk),
                .rst_n    (rst_n),
                .cap      (flt_stb),
                .cap_addr (flt_addr),
                .sw_ld    (sw_addr_ld),
                .sw_word  (sw_wdata),
                .q        (addr_q)
            );
        end else begin : g_no_addr
            assign addr_q = '0;
        end
    endgenerate

    // Read port: select one of the two registers.
    always_comb begin
        rd_data = rd_sel ? addr_q : stat_q;
    end

    AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> stat_q[POS_VALID]); // R2

    AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && stat_q[POS_VALID]) |=> stat_q[POS_OVWR]); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && !stat_q[POS_VALID]) |=> !stat_q[POS_OVWR]); // R3

    AST_WRITE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> (stat_q[POS_WRITE] == $past(flt_write))); // R4

    AST_CTX_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> (stat_q[POS_CTX +: CTX_W] == $past(flt_ctx))); // R5

    AST_SIDE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> (stat_q[POS_SIDE] == $past(flt_side))); // R6

    AST_TYPE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> ((stat_q[TYPE_TOP:POS_TYPE] == $past(flt_type)) &&
                     (stat_q[SPACE_TOP:POS_SPACE] == $past(flt_space)))); // R7

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flt_stb |=> (stat_q[POS_WRITE+1] == 1'b0 &&
                     stat_q[DW-1:SPACE_TOP+1] == '0)); // R8

    AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_stb && sw_stat_ld) |=> stat_q[POS_VALID]); // R10

endmodule

// File: tb/fault_status_unit_bench.sv
`timescale 1ns/1ps
module fault_status_unit_bench;

    localparam int DW   = 64;
    localparam int FT_W = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flt_stb = 1'b0;
    logic            flt_write = 1'b0;
    logic [1:0]      flt_ctx = '0;
    logic            flt_side = 1'b0;
    logic [FT_W-1:0] flt_type = '0;
    logic [7:0]      flt_space = '0;
    logic [DW-1:0]   flt_addr = '0;
    logic            sw_we = 1'b0;
    logic            sw_sel = 1'b0;
    logic [DW-1:0]   sw_wdata = '0;
    logic            rd_sel = 1'b0;
    logic [DW-1:0]   rd_data;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] exp_stat;
    logic [DW-1:0] exp_addr;

    always #2.5 clk = ~clk;

    fault_status_unit #(.DW(DW), .FT_W(FT_W), .HAS_ADDR(1'b1)) u_fault_status_unit (
        .clk(clk), .rst_n(rst_n), .flt_stb(flt_stb), .flt_write(flt_write),
        .flt_ctx(flt_ctx), .flt_side(flt_side), .flt_type(flt_type),
        .flt_space(flt_space), .flt_addr(flt_addr), .sw_we(sw_we),
        .sw_sel(sw_sel), .sw_wdata(sw_wdata), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // Expected status word per R2..R8.
    function automatic logic [DW-1:0] pack(input logic pv, input logic w,
        input logic [1:0] c, input logic s, input logic [FT_W-1:0] t,
        input logic [7:0] a);
        logic [DW-1:0] v;
        v = '0;
        v[0] = 1'b1;
        v[1] = pv;
        v[2] = w;
        v[5:4] = c;
        v[6] = s;
        v[12:7] = t;
        v[23:16] = a;
        return v;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read both registers through the read port and compare.
    task automatic read_both(input string req);
        rd_sel = 1'b0; #0.5;
        chk(req, rd_data, exp_stat);
        rd_sel = 1'b1; #0.5;
        chk(req, rd_data, exp_addr);
        rd_sel = 1'b0;
    endtask

    // One fault strobe, optionally with a software write on the same edge.
    task automatic fault(input logic w, input logic [1:0] c, input logic s,
        input logic [FT_W-1:0] t, input logic [7:0] a, input logic [DW-1:0] ad,
        input logic with_sw, input logic sel, input logic [DW-1:0] d);
        @(negedge clk);
        flt_stb = 1'b1; flt_write = w; flt_ctx = c; flt_side = s;
        flt_type = t; flt_space = a; flt_addr = ad;
        sw_we = with_sw; sw_sel = sel; sw_wdata = d;
        exp_stat = pack(exp_stat[0], w, c, s, t, a);
        exp_addr = ad;
        @(posedge clk); #1;
        flt_stb = 1'b0; sw_we = 1'b0;
    endtask

    task automatic sw_write(input logic sel, input logic [DW-1:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
        if (sel) exp_addr = d; else exp_stat = d;
        @(posedge clk); #1;
        sw_we = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        exp_stat = '0; exp_addr = '0;
        rst_n = 1'b1;
        #0.5;
        read_both("R1 reset");
    endtask

    task automatic t_first_fault();
        fault(1'b1, 2'd1, 1'b0, 6'h15, 8'h80, 64'h0000_1234_5678_9AB8, 1'b0, 1'b0, '0);
        read_both("R2 R4 R5 R7 R11 first fault");
        rd_sel = 1'b0; #0.5;
        chk("R3 first fault no overwrite", {63'd0, rd_data[1]}, 64'd0);
    endtask

    task automatic t_second_fault();
        fault(1'b0, 2'd2, 1'b1, 6'h2A, 8'h14, 64'hFFFF_0000_AAAA_5550, 1'b0, 1'b0, '0);
        read_both("R3 R6 second fault overwrite");
        chk("R3 overwrite bit", {63'd0, exp_stat[1]}, 64'd1);
    endtask

    task automatic t_clear_then_fault();
        sw_write(1'b0, 64'h0);
        read_both("R9 software clear");
        fault(1'b0, 2'd0, 1'b0, 6'h01, 8'h04, 64'h40, 1'b0, 1'b0, '0);
        read_both("R3 no overwrite after clear");
    endtask

    task automatic t_spare_bits();
        sw_write(1'b0, '1);
        read_both("R9 software all ones");
        fault(1'b1, 2'd3, 1'b1, 6'h3F, 8'hFF, '1, 1'b0, 1'b0, '0);
        read_both("R8 spare bits cleared");
    endtask

    task automatic t_collision();
        fault(1'b0, 2'd1, 1'b1, 6'h0C, 8'h5A, 64'h1111_2222_3333_4440, 1'b1, 1'b0, '1);
        read_both("R10 fault beats status write");
        fault(1'b1, 2'd0, 1'b0, 6'h30, 8'hA5, 64'h0BAD_F00D_0000_0008, 1'b1, 1'b1, '1);
        read_both("R10 fault beats address write");
    endtask

    task automatic t_hold();
        @(negedge clk);
        flt_write = ~flt_write; flt_ctx = 2'd2; flt_side = ~flt_side;
        flt_type = 6'h2B; flt_space = 8'h77; flt_addr = 64'hDEAD_BEEF;
        sw_wdata = 64'h5555; sw_sel = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        read_both("R12 hold without strobe");
    endtask

    task automatic t_addr_write();
        sw_write(1'b1, 64'hCAFE_0000_1234_0000);
        read_both("R9 R13 address write and read select");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        exp_stat = '0; exp_addr = '0;
        t_reset();
        t_first_fault();
        t_second_fault();
        t_clear_then_fault();
        t_spare_bits();
        t_collision();
        t_hold();
        t_addr_write();
        t_reset();
        finish_run();
    end

endmodule